// File: doc/BRIEF.md
# Reduced 2x2 Inverse DCT

This block turns one 8x8 block of signed quantized transform coefficients into a 2x2 block of unsigned 8-bit pixels, the scaled-down reconstruction used when an image is decoded at one eighth of its size. Each coefficient arrives together with its 16-bit quantization multiplier and its position in the block. Only positions whose row and column are both in the set {0, 1, 3, 5, 7} affect the result. The block multiplies those coefficients by their multipliers and keeps 25 of them. It then runs a column pass and a row pass. Each pass is one butterfly: the even term is the index-0 value scaled up, and the odd term is a four-tap weighted sum with 13-bit-fraction weights. A descale, a level shift to mid-grey and a clamp finish the result. All arithmetic is integer. Accumulators are 32 bits wide and wrap.

A sequencer with four states drives the block. ST_IDLE waits for `start` and moves to ST_LOAD. ST_LOAD takes 64 valid words and moves to ST_COLS on the last one. ST_COLS spends five cycles, one per used column. ST_ROWS spends two cycles, one per intermediate row, and then returns to ST_IDLE. On that return the 2x2 result is presented with a one-cycle `done` strobe.

Top module: `idct2_reduced`

## Requirements
- R1: After reset, `busy`, `done` and `pix_out` are all zero.
- R2: `start` sampled in ST_IDLE makes `busy` high from the next cycle. `start` sampled while busy is ignored, so latency and result are unchanged.
- R3: In ST_LOAD exactly 64 words with `in_valid` high are accepted, and cycles with `in_valid` low are skipped. `done` rises on the 7th rising edge after the edge that accepts the 64th word, lasts one cycle, and coincides with `busy` falling.
- R4: Coefficients whose row or column index (`in_idx[5:3]` is the row, `in_idx[2:0]` the column) is 2, 4 or 6 have no effect on the output.
- R5: Dequantization keeps the low 16 bits of coefficient times multiplier as a signed value. For example, 256 x 257 behaves as 256.
- R6: With only the DC coefficient non-zero, all four pixels are equal. DC product 8 gives 129, and an all-zero block gives 128.
- R7: Pixels saturate to 0..255. DC product +2000 gives 255 everywhere and -2000 gives 0 everywhere.
- R8: `pix_out` byte 0 is row 0 column 0, byte 1 is row 0 column 1, byte 2 is row 1 column 0, and byte 3 is row 1 column 1. Column 0 comes from the butterfly sum and column 1 from the difference. Row 0 comes from the pass-1 sum and row 1 from the pass-1 difference. `pix_out` changes only together with `done`.
- R9: Pass 1 computes, per used column, (x0<<15) plus or minus (29692*x1 - 10426*x3 + 6967*x5 - 5906*x7), wrapping at 32 bits. It adds 4096, shifts arithmetically right by 13 and keeps 16 bits. Pass 2 applies the same sum and difference along each intermediate row. It then takes bits 31:16, adds 8, shifts arithmetically right by 4, adds 128 and clamps.
- R10: `in_valid` while in ST_IDLE is ignored: `busy` and `done` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (sampled in ST_IDLE) |
| in_valid | input | 1 | Coefficient word present |
| in_idx | input | 6 | Position: row in bits 5:3, column in bits 2:0 |
| in_coef | input | 16 | Signed quantized coefficient |
| in_quant | input | 16 | Quantization multiplier for that position |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle strobe, result valid |
| pix_out | output | 32 | Four 8-bit pixels, layout per R8 |

## Verification
A wrong load count or a stuck sequencer state shows at the ports as a `done` that arrives early, late or never. The bench measures the latency on every block, so such a fault is caught on the first block. Errors in the weights, in the column selection or in the rounding change at least one pixel on the next `done`. Random, full-range and extreme blocks are compared with an independent integer model, which also exposes a missing wrap or a missing clamp. A swapped sum and difference, or a swapped row order, shows at once in the asymmetric directed patterns, because they give different bytes in each position.

// File: rtl/idct2_pkg.sv
package idct2_pkg;

    localparam int USED_N = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COLS,
        ST_ROWS
    } seq_state_t;

    // Odd-part weights in Q13 for taps 1, 3, 5, 7
    localparam int signed WT_1 = 29692;
    localparam int signed WT_3 = -10426;
    localparam int signed WT_5 = 6967;
    localparam int signed WT_7 = -5906;

    // Maps a 3-bit row/column index to {hit, slot}; only 0,1,3,5,7 hit
    function automatic logic [3:0] slot_of(input logic [2:0] k);
        logic [3:0] r;
        unique case (k)
            3'd0:    r = 4'b1_000;
            3'd1:    r = 4'b1_001;
            3'd3:    r = 4'b1_010;
            3'd5:    r = 4'b1_011;
            3'd7:    r = 4'b1_100;
            default: r = 4'b0_000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/idct2_dequant.sv
module idct2_dequant #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] coef,
    input  logic signed [W-1:0] quant,
    output logic signed [W-1:0] prod
);
    // Low half of the product, reinterpreted as signed
    assign prod = W'(coef * quant);
endmodule

// File: rtl/idct2_butterfly.sv
module idct2_butterfly
    import idct2_pkg::*;
#(
    parameter int IN_W       = 16,
    parameter int ACC_W      = 32,
    parameter int EVEN_SHIFT = 15
) (
    input  logic signed [IN_W-1:0]  x0,
    input  logic signed [IN_W-1:0]  x1,
    input  logic signed [IN_W-1:0]  x3,
    input  logic signed [IN_W-1:0]  x5,
    input  logic signed [IN_W-1:0]  x7,
    output logic signed [ACC_W-1:0] sum,
    output logic signed [ACC_W-1:0] diff
);
    localparam logic signed [ACC_W-1:0] K1 = ACC_W'(WT_1);
    localparam logic signed [ACC_W-1:0] K3 = ACC_W'(WT_3);
    localparam logic signed [ACC_W-1:0] K5 = ACC_W'(WT_5);
    localparam logic signed [ACC_W-1:0] K7 = ACC_W'(WT_7);

    logic signed [ACC_W-1:0] e0, e1, e3, e5, e7;
    logic signed [ACC_W-1:0] even_t, odd_t;

    assign e0 = ACC_W'(x0);
    assign e1 = ACC_W'(x1);
    assign e3 = ACC_W'(x3);
    assign e5 = ACC_W'(x5);
    assign e7 = ACC_W'(x7);

    assign even_t = e0 <<< EVEN_SHIFT;
    // Wrapping 32-bit multiply-accumulate
    assign odd_t  = (e1 * K1) + (e3 * K3) + (e5 * K5) + (e7 * K7);

    assign sum  = even_t + odd_t;
    assign diff = even_t - odd_t;
endmodule

// File: rtl/idct2_round_narrow.sv
module idct2_round_narrow #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 16,
    parameter int SHIFT = 13
) (
    input  logic signed [ACC_W-1:0] din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic signed [ACC_W:0] RND = (ACC_W+1)'(1) <<< (SHIFT-1);
    // Rounding done one bit wider so the bias cannot wrap
    assign dout = OUT_W'(((ACC_W+1)'(din) + RND) >>> SHIFT);
endmodule

// File: rtl/idct2_pixel.sv
module idct2_pixel #(
    parameter int ACC_W  = 32,
    parameter int HI_W   = 16,
    parameter int SHIFT  = 4,
    parameter int CENTER = 128,
    parameter int PIX_W  = 8
) (
    input  logic signed [ACC_W-1:0] din,
    output logic [PIX_W-1:0]        pix
);
    localparam logic signed [HI_W:0] RND = (HI_W+1)'(1) <<< (SHIFT-1);
    localparam logic signed [HI_W:0] CTR = (HI_W+1)'(CENTER);
    localparam logic signed [HI_W:0] PMAX = (HI_W+1)'((1 << PIX_W) - 1);
    localparam int SAT_HI = ((1 << PIX_W) - 1 - CENTER) * (1 << SHIFT) + (1 << SHIFT) - (1 << (SHIFT-1));
    localparam int SAT_LO = -(CENTER * (1 << SHIFT)) - (1 << (SHIFT-1));

    logic signed [HI_W-1:0] hi;
    logic signed [HI_W:0]   rs;
    logic signed [HI_W:0]   lvl;

    assign hi  = HI_W'(din >>> (ACC_W - HI_W));
    assign rs  = ((HI_W+1)'(hi) + RND) >>> SHIFT;
    assign lvl = rs + CTR;

    always_comb begin
        if (lvl < 0)
            pix = '0;
        else if (lvl > PMAX)
            pix = '1;
        else
            pix = PIX_W'(lvl);
    end

    // Clamp relation between the descale input and the pixel
    always_comb begin
        if (int'(hi) >= SAT_HI)
            assert_sat_high_R7: assert (pix == PIX_W'((1 << PIX_W) - 1));
        if (int'(hi) < SAT_LO)
            assert_sat_low_R7: assert (pix == '0);
    end
endmodule

// File: rtl/idct2_reduced.sv
module idct2_reduced
    import idct2_pkg::*;
#(
    parameter int COEF_W    = 16,
    parameter int ACC_W     = 32,
    parameter int FRAC_BITS = 13,
    parameter int PIX_W     = 8,
    parameter int BLOCK_N   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 in_valid,
    input  logic [5:0]           in_idx,
    input  logic [COEF_W-1:0]    in_coef,
    input  logic [COEF_W-1:0]    in_quant,
    output logic                 busy,
    output logic                 done,
    output logic [4*PIX_W-1:0]   pix_out
);
    localparam int BLK_WORDS  = BLOCK_N * BLOCK_N;
    localparam int IDX_W      = $clog2(BLK_WORDS);
    localparam int HALF_W     = IDX_W / 2;
    localparam int EVEN_SHIFT = FRAC_BITS + 2;
    localparam int OUT_SHIFT  = FRAC_BITS + 7 - COEF_W;
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(BLK_WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_COL  = IDX_W'(USED_N - 1);
    localparam logic [IDX_W-1:0] LAST_ROW  = IDX_W'(1);

    seq_state_t         state, state_nx;
    logic [IDX_W-1:0]   cnt, cnt_nx;

    logic signed [COEF_W-1:0] dq  [USED_N][USED_N];
    logic signed [COEF_W-1:0] mid [2][USED_N];
    logic signed [COEF_W-1:0] prod;
    logic [3:0]               row_hit, col_hit;
    logic                     take_word;

    logic signed [COEF_W-1:0] bx [USED_N];
    logic signed [ACC_W-1:0]  bf_out [2];
    logic signed [COEF_W-1:0] nar [2];
    logic [PIX_W-1:0]         pixv [2];
    logic [2*PIX_W-1:0]       row0_hold;
    logic [2:0]               sel;

    // ---------------- input dequantization ----------------
    idct2_dequant #(.W(COEF_W)) u_dq (
        .coef  (in_coef),
        .quant (in_quant),
        .prod  (prod)
    );

    assign row_hit   = slot_of(in_idx[IDX_W-1:HALF_W]);
    assign col_hit   = slot_of(in_idx[HALF_W-1:0]);
    assign take_word = (state == ST_LOAD) && in_valid;
    assign sel       = cnt[2:0];

    // ---------------- shared butterfly operand mux ----------------
    always_comb begin
        for (int k = 0; k < USED_N; k++) begin
            if (state == ST_ROWS)
                bx[k] = mid[cnt[0]][k];
            else
                bx[k] = dq[k][sel];
        end
    end

    idct2_butterfly #(
        .IN_W       (COEF_W),
        .ACC_W      (ACC_W),
        .EVEN_SHIFT (EVEN_SHIFT)
    ) u_bf (
        .x0   (bx[0]),
        .x1   (bx[1]),
        .x3   (bx[2]),
        .x5   (bx[3]),
        .x7   (bx[4]),
        .sum  (bf_out[0]),
        .diff (bf_out[1])
    );

    // Index 0 = sum branch, index 1 = difference branch
    for (genvar g = 0; g < 2; g++) begin : g_branch
        idct2_round_narrow #(
            .ACC_W (ACC_W),
            .OUT_W (COEF_W),
            .SHIFT (FRAC_BITS)
        ) u_nar (
            .din  (bf_out[g]),
            .dout (nar[g])
        );

        idct2_pixel #(
            .ACC_W  (ACC_W),
            .HI_W   (COEF_W),
            .SHIFT  (OUT_SHIFT),
            .CENTER (1 << (PIX_W - 1)),
            .PIX_W  (PIX_W)
        ) u_pix (
            .din (bf_out[g]),
            .pix (pixv[g])
        );
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_LOAD;
                    cnt_nx   = '0;
                end
            end
            ST_LOAD: begin
                if (in_valid) begin
                    if (cnt == LAST_WORD) begin
                        state_nx = ST_COLS;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            ST_COLS: begin
                if (cnt == LAST_COL) begin
                    state_nx = ST_ROWS;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_ROWS: begin
                if (cnt == LAST_ROW) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // ---------------- working storage ----------------
    always_ff @(posedge clk) begin
        if (take_word && row_hit[3] && col_hit[3])
            dq[row_hit[2:0]][col_hit[2:0]] <= prod;
        if (state == ST_COLS) begin
            mid[0][sel] <= nar[0];
            mid[1][sel] <= nar[1];
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            pix_out   <= '0;
            row0_hold <= '0;
        end else begin
            busy <= (state_nx != ST_IDLE);
            done <= (state == ST_ROWS) && (cnt == LAST_ROW);
            if (state == ST_ROWS && cnt == '0)
                row0_hold <= {pixv[1], pixv[0]};
            if (state == ST_ROWS && cnt == LAST_ROW)
                pix_out <= {pixv[1], pixv[0], row0_hold};
        end
    end

    // ---------------- assertions ----------------
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> busy);

    assert_load_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !in_valid) |=> (state == ST_LOAD && $stable(cnt)));

    assert_last_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_word && cnt == LAST_WORD) |=> (state == ST_COLS));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && state == ST_IDLE));

    assert_pix_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_out != $past(pix_out)) |-> done);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> (!busy && !done));
endmodule

// File: tb/tb_idct2_reduced.sv
module tb_idct2_reduced;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_idx = '0;
    logic [15:0] in_coef = '0;
    logic [15:0] in_quant = '0;
    logic        busy, done;
    logic [31:0] pix_out;

    always #4 clk = ~clk;   // 125 MHz

    idct2_reduced dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .in_idx   (in_idx),
        .in_coef  (in_coef),
        .in_quant (in_quant),
        .busy     (busy),
        .done     (done),
        .pix_out  (pix_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    shortint cf [64];
    shortint qt [64];

    // Directed table: pattern kind and expected pixel bus
    localparam int TBL_N = 8;
    localparam logic [2:0] TBL_KIND [TBL_N] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam logic [31:0] TBL_EXP [TBL_N] = '{
        32'h80808080,   // R6 zero block
        32'h81818181,   // R6 DC product 8
        32'hFFFFFFFF,   // R7 DC +2000
        32'h00000000,   // R7 DC -2000
        32'h81818181,   // R4 unused positions loaded with junk
        32'hA0A0A0A0,   // R5 256*257 wraps to 256
        32'h758B758B,   // R8 column order
        32'h75758B8B    // R8 row order
    };

    function automatic string req_of(input logic [2:0] k);
        case (k)
            3'd0, 3'd1: return "R6";
            3'd2, 3'd3: return "R7";
            3'd4:       return "R4";
            3'd5:       return "R5";
            default:    return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sat_pix(input int v);
        int hi, t;
        hi = int'(shortint'(v >>> 16));
        t  = 128 + ((hi + 8) >>> 4);
        if (t < 0) return 8'd0;
        if (t > 255) return 8'd255;
        return 8'(t);
    endfunction

    // Independent integer model of the requirement equations (R9)
    function automatic logic [31:0] model();
        int u [5] = '{0, 1, 3, 5, 7};
        shortint d [5][5];
        shortint m [2][5];
        logic [7:0] p [2][2];
        int e, o, s, df;
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++)
                d[r][c] = shortint'(int'(cf[u[r]*8+u[c]]) * int'(qt[u[r]*8+u[c]]));
        for (int c = 0; c < 5; c++) begin
            e  = int'(d[0][c]) <<< 15;
            o  = 29692*int'(d[1][c]) - 10426*int'(d[2][c]) + 6967*int'(d[3][c]) - 5906*int'(d[4][c]);
            s  = e + o;
            df = e - o;
            m[0][c] = shortint'((longint'(s) + 4096) >>> 13);
            m[1][c] = shortint'((longint'(df) + 4096) >>> 13);
        end
        for (int r = 0; r < 2; r++) begin
            e  = int'(m[r][0]) <<< 15;
            o  = 29692*int'(m[r][1]) - 10426*int'(m[r][2]) + 6967*int'(m[r][3]) - 5906*int'(m[r][4]);
            p[r][0] = sat_pix(e + o);
            p[r][1] = sat_pix(e - o);
        end
        return {p[1][1], p[1][0], p[0][1], p[0][0]};
    endfunction

    task automatic fill(input logic [2:0] kind);
        for (int i = 0; i < 64; i++) begin cf[i] = 0; qt[i] = 1; end
        case (kind)
            3'd1: cf[0] = 8;
            3'd2: cf[0] = 2000;
            3'd3: cf[0] = -2000;
            3'd4: begin
                cf[0] = 8;
                for (int i = 0; i < 64; i++)
                    if ((i/8) % 2 == 0 && (i/8) != 0 || (i%8) % 2 == 0 && (i%8) != 0) begin
                        cf[i] = 30000; qt[i] = 3;
                    end
            end
            3'd5: begin cf[0] = 256; qt[0] = 257; end
            3'd6: cf[1] = 100;
            3'd7: cf[8] = 100;
            default: ;
        endcase
    endtask

    task automatic fill_random(input int mode);
        for (int i = 0; i < 64; i++) begin
            case (mode)
                0: begin cf[i] = shortint'($signed($urandom_range(0, 127)) - 64); qt[i] = shortint'($urandom_range(1, 32)); end
                1: begin cf[i] = shortint'($urandom); qt[i] = shortint'($urandom); end
                2: begin cf[i] = (i % 2 == 0) ? 16'sh7FFF : -16'sh8000; qt[i] = 16'sh7FFF; end
                3: begin cf[i] = -16'sh8000; qt[i] = 1; end
                default: begin cf[i] = 16'sh7FFF; qt[i] = 1; end
            endcase
        end
    endtask

    // Called at a negedge with the block idle; returns at the negedge where done is seen
    task automatic run_block(input bit bubbles, input bit poke_start,
                             output int lat, output logic [31:0] px);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (bubbles && (i % 7 == 3)) begin
                in_valid = 1'b0; in_idx = 6'(i); in_coef = 16'h5A5A; in_quant = 16'h0007;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_idx   = 6'(i);
            in_coef  = cf[i];
            in_quant = qt[i];
            start    = poke_start && (i == 20);
            @(negedge clk);
        end
        in_valid = 1'b0;
        start    = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        px = pix_out;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lat;
        logic [31:0] px;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 pix_out", pix_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed table walk
        for (int k = 0; k < TBL_N; k++) begin
            fill(TBL_KIND[k]);
            run_block(1'b0, 1'b0, lat, px);
            chk(req_of(TBL_KIND[k]), px, TBL_EXP[k]);
            chk("R3 latency", 32'(lat), 32'd8);
            chk("R3 busy low at done", 32'(busy), 32'd0);
            @(negedge clk);
            chk("R3 done one cycle", 32'(done), 32'd0);
        end

        // R2 busy after start, start while busy ignored
        fill_random(0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", 32'(busy), 32'd1);
        // already in load: finish the block with a stray start mid-load
        for (int i = 0; i < 64; i++) begin
            in_valid = 1'b1; in_idx = 6'(i); in_coef = cf[i]; in_quant = qt[i];
            start = (i == 20);
            @(negedge clk);
        end
        in_valid = 1'b0; start = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin @(negedge clk); lat++; end
        chk("R2 stray start latency", 32'(lat), 32'd8);
        chk("R2 stray start result", pix_out, model());
        @(negedge clk);
        chk("R2 idle after block", 32'(busy), 32'd0);

        // R3 bubbles in the load stream
        fill_random(0);
        run_block(1'b1, 1'b0, lat, px);
        chk("R3 bubbles result", px, model());
        chk("R3 bubbles latency", 32'(lat), 32'd8);
        @(negedge clk);

        // R9 random blocks against the model
        for (int n = 0; n < 24; n++) begin
            fill_random(n % 2);
            run_block(1'b0, n == 5, lat, px);
            chk("R9 random", px, model());
            @(negedge clk);
        end

        // R5 / R7 extreme blocks
        for (int mode = 2; mode < 5; mode++) begin
            fill_random(mode);
            run_block(1'b0, 1'b0, lat, px);
            chk("R7 extreme", px, model());
            @(negedge clk);
        end

        // R10 valid words in idle are ignored
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_idx = 6'd0; in_coef = 16'h1234; in_quant = 16'h0003;
            @(negedge clk);
            chk("R10 busy in idle", 32'(busy), 32'd0);
            chk("R10 done in idle", 32'(done), 32'd0);
        end
        in_valid = 1'b0;
        fill(3'd1);
        run_block(1'b0, 1'b0, lat, px);
        chk("R10 next block clean", px, 32'h81818181);
        @(negedge clk);

        finish_run();
    end
endmodule